// File: doc/BRIEF.md
# Protected Half-Bridge and High-Side Gate Controller

This block turns register-level drive requests into gate enables for a set of half-bridges and a set of high-side switches, all sharing one PWM input. For every half-bridge a pair of request bits picks the low device, the high device, or a chopping mode. In chopping mode the high device follows the PWM input. During the PWM off phase the low device can optionally carry the recirculation current. A global stage enable gates every output. A break-before-make rule keeps both devices of a leg from ever conducting together.

The block also protects the stage. Supply-fault events (low voltage and high voltage) are latched into sticky flags. While a flag is set, the half-bridges are shut down unless a mask input keeps them running. Each high-side switch in static-on mode latches its overcurrent comparator into a sticky flag and stays off until software clears that flag. In PWM mode the switch chops itself off while the comparator is high. The per-switch PWM-mode bits are held in a register inside the block.

Top module: `pstage_ctrl`

## Requirements
- R1: When `stage_en` is low at a clock edge, every half-bridge gate and every high-side gate is low after that edge.
- R2: The two gates of one half-bridge are never high in the same cycle. A gate may turn on only after both gates of its leg have been low for DEAD_CYC consecutive cycles (default 1).
- R3: With only the low request bit set, the low gate turns on. With only the high request bit set, the high gate turns on. With neither bit set, both gates are off.
- R4: With both request bits set, the high gate follows `pwm_in`. During the low phase of `pwm_in`, the low gate is on if `recirc_lo` is 1 and off if it is 0.
- R5: A high level on `lv_evt` (bit 0 of `fault_flags`) or on `hv_evt` (bit 1) sets a sticky flag. Writing 1 to the matching bit of `fault_clr` clears it, and a set in the same cycle wins over the clear. While an event or flag is present and `fault_mask` is 0, all half-bridge gates are off after the next edge, even if their request bits stay set.
- R6: With `fault_mask` at 1, the flags still latch but the half-bridge gates ignore them.
- R7: A high-side switch with its on bit set and its PWM-mode bit clear drives its gate high. If `hs_oc_in` is high for that switch while `stage_en` is set, its `hs_oc_flag` becomes set and the gate goes off. The gate stays off until a 1 is written to `hs_oc_clr` for that switch, and a set in the same cycle wins over the clear.
- R8: A high-side switch with its PWM-mode bit set drives `pwm_in & ~hs_oc_in` on its gate, whatever its on bit is, and never sets its overcurrent flag.
- R9: Reset clears every PWM-mode bit, every fault flag and every overcurrent flag, and turns every gate off.
- R10: A cycle with `hs_pwm_we` high loads `hs_pwm_wdata` into the PWM-mode bits, and the new value appears on `hs_pwm_en` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_en | input | 1 | Global power-stage enable |
| hb_lo_req | input | NUM_HB | Low-device request per half-bridge |
| hb_hi_req | input | NUM_HB | High-device request per half-bridge |
| recirc_lo | input | 1 | 1: recirculate through the low device in the PWM off phase |
| fault_mask | input | 1 | 1: supply faults do not shut the half-bridges down |
| pwm_in | input | 1 | Shared PWM input |
| lv_evt | input | 1 | Low-voltage event |
| hv_evt | input | 1 | High-voltage event |
| fault_clr | input | 2 | Write-1 clear of the fault flags (bit 0 low voltage, bit 1 high voltage) |
| hs_on | input | NUM_HS | Static-on request per high-side switch |
| hs_pwm_we | input | 1 | Write strobe of the PWM-mode register |
| hs_pwm_wdata | input | NUM_HS | New PWM-mode bits |
| hs_oc_in | input | NUM_HS | Overcurrent comparator per high-side switch |
| hs_oc_clr | input | NUM_HS | Write-1 clear of the overcurrent flags |
| hb_gate_hi | output | NUM_HB | High-device gate enables |
| hb_gate_lo | output | NUM_HB | Low-device gate enables |
| hs_gate | output | NUM_HS | High-side switch gate enables |
| hs_oc_flag | output | NUM_HS | Sticky overcurrent flags |
| hs_pwm_en | output | NUM_HS | Current PWM-mode bits |
| fault_flags | output | 2 | Sticky supply-fault flags (bit 0 low voltage, bit 1 high voltage) |

## Verification
Two pairs of functions can land in the same cycle. A supply fault can arrive while a leg is inside its dead-time window, or while a PWM edge is reversing which device should conduct. A flag can also be set and cleared in the same cycle. Directed sequences raise `lv_evt` exactly as `pwm_in` falls with recirculation enabled, and assert an event or overcurrent together with its clear strobe. Random phases add many more such collisions. Every cycle, all outputs are compared with a bench model built from the rules above, and both gates of each leg are checked for overlap.

// File: rtl/pstage_pkg.sv
package pstage_pkg;
   // Bit positions of the supply-fault flags
   localparam int FLT_LV = 0;
   localparam int FLT_HV = 1;
   localparam int FLT_W  = 2;

   // Operating mode of one high-side switch
   typedef enum logic [1:0] {
      HS_OFF    = 2'd0,
      HS_STATIC = 2'd1,
      HS_CHOP   = 2'd2
   } hs_mode_e;
endpackage

// File: rtl/supply_guard.sv
module supply_guard
   import pstage_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lv_evt,
   input  logic             hv_evt,
   input  logic [FLT_W-1:0] flt_clr,
   input  logic             flt_mask,
   output logic [FLT_W-1:0] flt_q,
   output logic             hb_block
);
   logic [FLT_W-1:0] evt;
   logic [FLT_W-1:0] flt_d;

   always_comb begin
      evt         = '0;
      evt[FLT_LV] = lv_evt;
      evt[FLT_HV] = hv_evt;
      // set wins over clear
      flt_d       = (flt_q & ~flt_clr) | evt;
      hb_block    = ((|flt_q) | (|evt)) & ~flt_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flt_q <= '0;
      else        flt_q <= flt_d;
   end

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q[FLT_LV] && !flt_clr[FLT_LV]) |=> flt_q[FLT_LV]);
   // R5
   hv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hv_evt |=> flt_q[FLT_HV]);
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
   parameter int DEAD_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic leg_en,
   input  logic lo_req,
   input  logic hi_req,
   input  logic pwm,
   input  logic recirc,
   output logic gate_hi,
   output logic gate_lo
);
   logic want_hi, want_lo, ready;
   logic hi_d, lo_d;

   always_comb begin
      want_hi = leg_en & hi_req & (lo_req ? pwm : 1'b1);
      want_lo = leg_en & lo_req & (hi_req ? (~pwm & recirc) : 1'b1);
   end

   generate
      if (DEAD_CYC == 0) begin : g_nodead
         assign ready = 1'b1;
      end else begin : g_dead
         localparam int CW = $clog2(DEAD_CYC + 1);
         localparam logic [CW-1:0] CMAX = CW'(DEAD_CYC);
         logic [CW-1:0] quiet_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  quiet_q <= CMAX;
            else if (gate_hi | gate_lo)  quiet_q <= '0;
            else if (quiet_q != CMAX)    quiet_q <= quiet_q + 1'b1;
         end
         assign ready = (quiet_q == CMAX);
      end
   endgenerate

   always_comb begin
      hi_d = want_hi & ~gate_lo & (gate_hi | ready);
      lo_d = want_lo & ~gate_hi & (gate_lo | ready);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
      end else begin
         gate_hi <= hi_d;
         gate_lo <= lo_d;
      end
   end

   // R2
   lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> !$past(gate_hi));
   // R2
   hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> !$past(gate_lo));
endmodule

// File: rtl/hs_switch.sv
module hs_switch
   import pstage_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stage_en,
   input  logic on_req,
   input  logic pwm_mode,
   input  logic pwm,
   input  logic oc_in,
   input  logic oc_clr,
   output logic gate,
   output logic oc_flag
);
   hs_mode_e mode;
   logic     gate_d, flag_d;

   always_comb begin
      if (pwm_mode)    mode = HS_CHOP;
      else if (on_req) mode = HS_STATIC;
      else             mode = HS_OFF;

      flag_d = oc_flag & ~oc_clr;
      gate_d = 1'b0;
      case (mode)
         HS_CHOP:   gate_d = pwm & ~oc_in;
         HS_STATIC: begin
            gate_d = ~oc_flag & ~oc_in;
            if (oc_in) flag_d = 1'b1;
         end
         default:   gate_d = 1'b0;
      endcase
      if (!stage_en) begin
         gate_d = 1'b0;
         flag_d = oc_flag & ~oc_clr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate    <= 1'b0;
         oc_flag <= 1'b0;
      end else begin
         gate    <= gate_d;
         oc_flag <= flag_d;
      end
   end

   // R7
   oc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_flag && !oc_clr) |=> oc_flag);
   // R7
   oc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_flag && !pwm_mode) |=> !gate);
   // R8
   chop_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && !oc_flag) |=> !oc_flag);
endmodule

// File: rtl/pstage_ctrl.sv
module pstage_ctrl
   import pstage_pkg::*;
#(
   parameter int NUM_HB   = 4,
   parameter int NUM_HS   = 3,
   parameter int DEAD_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_en,
   input  logic [NUM_HB-1:0] hb_lo_req,
   input  logic [NUM_HB-1:0] hb_hi_req,
   input  logic              recirc_lo,
   input  logic              fault_mask,
   input  logic              pwm_in,
   input  logic              lv_evt,
   input  logic              hv_evt,
   input  logic [1:0]        fault_clr,
   input  logic [NUM_HS-1:0] hs_on,
   input  logic              hs_pwm_we,
   input  logic [NUM_HS-1:0] hs_pwm_wdata,
   input  logic [NUM_HS-1:0] hs_oc_in,
   input  logic [NUM_HS-1:0] hs_oc_clr,
   output logic [NUM_HB-1:0] hb_gate_hi,
   output logic [NUM_HB-1:0] hb_gate_lo,
   output logic [NUM_HS-1:0] hs_gate,
   output logic [NUM_HS-1:0] hs_oc_flag,
   output logic [NUM_HS-1:0] hs_pwm_en,
   output logic [1:0]        fault_flags
);
   generate
      if (NUM_HB < 1 || NUM_HB > 64) begin : g_bad_hb
         $error("pstage_ctrl: NUM_HB out of range");
      end
      if (NUM_HS < 1 || NUM_HS > 64) begin : g_bad_hs
         $error("pstage_ctrl: NUM_HS out of range");
      end
      if (DEAD_CYC < 0 || DEAD_CYC > 255) begin : g_bad_dead
         $error("pstage_ctrl: DEAD_CYC out of range");
      end
   endgenerate

   logic hb_block;
   logic leg_en;

   supply_guard i_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .lv_evt   (lv_evt),
      .hv_evt   (hv_evt),
      .flt_clr  (fault_clr),
      .flt_mask (fault_mask),
      .flt_q    (fault_flags),
      .hb_block (hb_block)
   );

   assign leg_en = stage_en & ~hb_block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hs_pwm_en <= '0;
      else if (hs_pwm_we) hs_pwm_en <= hs_pwm_wdata;
   end

   generate
      for (genvar i = 0; i < NUM_HB; i++) begin : g_leg
         hb_leg #(.DEAD_CYC(DEAD_CYC)) i_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .leg_en  (leg_en),
            .lo_req  (hb_lo_req[i]),
            .hi_req  (hb_hi_req[i]),
            .pwm     (pwm_in),
            .recirc  (recirc_lo),
            .gate_hi (hb_gate_hi[i]),
            .gate_lo (hb_gate_lo[i])
         );
      end
      for (genvar j = 0; j < NUM_HS; j++) begin : g_hs
         hs_switch i_hs (
            .clk      (clk),
            .rst_n    (rst_n),
            .stage_en (stage_en),
            .on_req   (hs_on[j]),
            .pwm_mode (hs_pwm_en[j]),
            .pwm      (pwm_in),
            .oc_in    (hs_oc_in[j]),
            .oc_clr   (hs_oc_clr[j]),
            .gate     (hs_gate[j]),
            .oc_flag  (hs_oc_flag[j])
         );
      end
   endgenerate

   // R1
   stage_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_en |=> (hb_gate_hi == '0 && hb_gate_lo == '0 && hs_gate == '0));
   // R5
   fault_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fault_flags) && !fault_mask) |=> (hb_gate_hi == '0 && hb_gate_lo == '0));
   // R2
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_gate_hi & hb_gate_lo) == '0);
   // R10
   pwm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_pwm_we |=> hs_pwm_en == $past(hs_pwm_wdata));
endmodule

// File: tb/test_pstage_ctrl.sv
module test_pstage_ctrl;
   localparam int NHB  = 4;
   localparam int NHS  = 3;
   localparam int DEAD = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stage_en = 1'b0;
   logic [NHB-1:0] hb_lo_req = '0, hb_hi_req = '0;
   logic recirc_lo = 1'b0, fault_mask = 1'b0, pwm_in = 1'b0;
   logic lv_evt = 1'b0, hv_evt = 1'b0;
   logic [1:0] fault_clr = '0;
   logic [NHS-1:0] hs_on = '0, hs_pwm_wdata = '0, hs_oc_in = '0, hs_oc_clr = '0;
   logic hs_pwm_we = 1'b0;
   logic [NHB-1:0] hb_gate_hi, hb_gate_lo;
   logic [NHS-1:0] hs_gate, hs_oc_flag, hs_pwm_en;
   logic [1:0] fault_flags;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // bench model state
   logic [NHB-1:0] m_hi, m_lo;
   int             m_quiet [NHB];
   logic [NHS-1:0] m_hsg, m_oc, m_pen;
   logic [1:0]     m_flt;

   always #5 clk = ~clk;

   pstage_ctrl #(.NUM_HB(NHB), .NUM_HS(NHS), .DEAD_CYC(DEAD)) i_pstage_ctrl (
      .clk(clk), .rst_n(rst_n), .stage_en(stage_en),
      .hb_lo_req(hb_lo_req), .hb_hi_req(hb_hi_req), .recirc_lo(recirc_lo),
      .fault_mask(fault_mask), .pwm_in(pwm_in), .lv_evt(lv_evt), .hv_evt(hv_evt),
      .fault_clr(fault_clr), .hs_on(hs_on), .hs_pwm_we(hs_pwm_we),
      .hs_pwm_wdata(hs_pwm_wdata), .hs_oc_in(hs_oc_in), .hs_oc_clr(hs_oc_clr),
      .hb_gate_hi(hb_gate_hi), .hb_gate_lo(hb_gate_lo), .hs_gate(hs_gate),
      .hs_oc_flag(hs_oc_flag), .hs_pwm_en(hs_pwm_en), .fault_flags(fault_flags));

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_hi = '0; m_lo = '0; m_hsg = '0; m_oc = '0; m_pen = '0; m_flt = '0;
      for (int i = 0; i < NHB; i++) m_quiet[i] = DEAD;
   endtask

   // next state of the model from the inputs presently driven
   task automatic model_step();
      logic run_hb;
      logic [NHB-1:0] nh, nl;
      logic [NHS-1:0] ng, no;
      logic [1:0] ev;
      ev = {hv_evt, lv_evt};
      run_hb = stage_en && !(((m_flt | ev) != 0) && !fault_mask);
      for (int i = 0; i < NHB; i++) begin
         logic wh, wl;
         wh = 0; wl = 0;
         if (run_hb) begin
            if (hb_hi_req[i] && hb_lo_req[i]) begin
               wh = pwm_in; wl = !pwm_in && recirc_lo;
            end else begin
               wh = hb_hi_req[i]; wl = hb_lo_req[i];
            end
         end
         nh[i] = wh && !m_lo[i] && (m_hi[i] || m_quiet[i] >= DEAD);
         nl[i] = wl && !m_hi[i] && (m_lo[i] || m_quiet[i] >= DEAD);
         if (m_hi[i] || m_lo[i]) m_quiet[i] = 0;
         else if (m_quiet[i] < DEAD) m_quiet[i]++;
      end
      for (int j = 0; j < NHS; j++) begin
         no[j] = m_oc[j] && !hs_oc_clr[j];
         ng[j] = 0;
         if (stage_en) begin
            if (m_pen[j]) ng[j] = pwm_in && !hs_oc_in[j];
            else if (hs_on[j]) begin
               ng[j] = !m_oc[j] && !hs_oc_in[j];
               if (hs_oc_in[j]) no[j] = 1;
            end
         end
      end
      m_hi = nh; m_lo = nl; m_hsg = ng; m_oc = no;
      m_flt = (m_flt & ~fault_clr) | ev;
      if (hs_pwm_we) m_pen = hs_pwm_wdata;
   endtask

   task automatic compare(string thb, string ths);
      check({thb, " hb_gate_hi"}, 8'(hb_gate_hi), 8'(m_hi));
      check({thb, " hb_gate_lo"}, 8'(hb_gate_lo), 8'(m_lo));
      check("R2 overlap", 8'(hb_gate_hi & hb_gate_lo), 8'h00);
      check({ths, " hs_gate"}, 8'(hs_gate), 8'(m_hsg));
      check("R7 hs_oc_flag", 8'(hs_oc_flag), 8'(m_oc));
      check("R5 fault_flags", 8'(fault_flags), 8'(m_flt));
      check("R10 hs_pwm_en", 8'(hs_pwm_en), 8'(m_pen));
   endtask

   // inputs are set at a negedge; one clock later outputs are compared
   task automatic cycle(string thb, string ths);
      model_step();
      @(negedge clk);
      compare(thb, ths);
   endtask

   task automatic clear_strobes();
      lv_evt = 0; hv_evt = 0; fault_clr = '0; hs_oc_clr = '0; hs_pwm_we = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R9: reset state
      compare("R9", "R9");
      rst_n = 1;
      @(negedge clk);
      compare("R9", "R9");

      // R1: requests present but stage disabled
      hb_hi_req = 4'b0101; hb_lo_req = 4'b1010; hs_on = '1;
      repeat (3) cycle("R1", "R1");
      check("R1 all off", 8'(hb_gate_hi | hb_gate_lo | hs_gate), 8'h00);

      // R3: single-bit requests
      stage_en = 1;
      repeat (3) cycle("R3", "R7");
      check("R3 hi legs", 8'(hb_gate_hi), 8'h05);
      check("R3 lo legs", 8'(hb_gate_lo), 8'h0A);

      // R4: chopping with recirculation through the low device
      hb_hi_req = '1; hb_lo_req = '1; recirc_lo = 1;
      for (int k = 0; k < 12; k++) begin
         pwm_in = (k % 4) < 2;
         cycle("R4", "R7");
      end
      recirc_lo = 0;
      for (int k = 0; k < 8; k++) begin
         pwm_in = (k % 4) < 2;
         cycle("R4", "R7");
      end

      // R5: fault lands on a PWM falling edge, requests stay set
      recirc_lo = 1; pwm_in = 1;
      repeat (3) cycle("R4", "R7");
      pwm_in = 0; lv_evt = 1;
      cycle("R5", "R7");
      lv_evt = 0;
      repeat (3) cycle("R5", "R7");
      check("R5 shut legs", 8'(hb_gate_hi | hb_gate_lo), 8'h00);
      // clear and set in the same cycle: set wins
      fault_clr = 2'b11; hv_evt = 1;
      cycle("R5", "R7");
      check("R5 set wins", 8'(fault_flags), 8'b10);
      clear_strobes(); fault_clr = 2'b10;
      cycle("R5", "R7");
      fault_clr = '0;
      repeat (4) cycle("R5", "R7");

      // R6: masked faults latch but do not shut down
      fault_mask = 1; hv_evt = 1;
      cycle("R6", "R7");
      hv_evt = 0;
      repeat (4) cycle("R6", "R7");
      fault_mask = 0; fault_clr = 2'b11;
      cycle("R5", "R7");
      fault_clr = '0;

      // R7: overcurrent in static mode, with set/clear collision
      hs_oc_in = 3'b010;
      cycle("R3", "R7");
      hs_oc_in = 3'b010; hs_oc_clr = 3'b010;
      cycle("R3", "R7");
      hs_oc_in = '0; hs_oc_clr = '0;
      repeat (3) cycle("R3", "R7");
      check("R7 switch held off", 8'(hs_gate), 8'b101);
      hs_oc_clr = 3'b010;
      cycle("R3", "R7");
      hs_oc_clr = '0;
      cycle("R3", "R7");

      // R8 / R10: PWM mode on switches
      hs_pwm_we = 1; hs_pwm_wdata = 3'b011;
      cycle("R3", "R10");
      hs_pwm_we = 0;
      for (int k = 0; k < 8; k++) begin
         pwm_in = k[1];
         hs_oc_in = (k == 5) ? 3'b001 : 3'b000;
         cycle("R4", "R8");
      end
      hs_oc_in = '0;

      // R9: reset mid-run
      rst_n = 0;
      @(negedge clk);
      model_reset();
      compare("R9", "R9");
      rst_n = 1;

      // random phase
      for (int n = 0; n < 3000; n++) begin
         clear_strobes();
         if ($urandom_range(2) == 0) pwm_in = ~pwm_in;
         if (n % 37 == 0) begin
            hb_hi_req = 4'($urandom); hb_lo_req = 4'($urandom);
            hs_on = 3'($urandom); recirc_lo = 1'($urandom);
            fault_mask = ($urandom_range(3) == 0);
         end
         stage_en = ($urandom_range(15) != 0);
         lv_evt = ($urandom_range(63) == 0);
         hv_evt = ($urandom_range(63) == 0);
         if ($urandom_range(15) == 0) fault_clr = 2'($urandom);
         for (int j = 0; j < NHS; j++) begin
            hs_oc_in[j] = ($urandom_range(15) == 0);
            hs_oc_clr[j] = ($urandom_range(11) == 0);
         end
         if ($urandom_range(31) == 0) begin
            hs_pwm_we = 1; hs_pwm_wdata = 3'($urandom);
         end
         cycle("R1/R2/R3/R4/R5/R6", "R7/R8");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule